// File: doc/BRIEF.md
# Distributed Queue Slot Access Node

This block is one station on a pair of slotted buses that run in opposite directions. The station asks for transmit time by marking the request flag in a slot header on the reservation bus. It is then served by a free slot on the data bus, which flows the other way. No central arbiter is involved. Each station keeps two local counts. One holds the foreign requests queued ahead of its own. The other holds the requests that arrived after its own was placed. These counts decide which free data slot the station may take, so stations are served in request order.

The client puts one packet into a one-deep local queue with a load pulse. The station then places a single request on the first reservation-bus slot whose request flag is still clear. It lets one free data slot pass for every request queued ahead of it. It marks the next free slot busy and pulses a claim output aligned with that outgoing slot. Both slot-header paths are registered, so each station adds one clock of latency per bus.

Top module: `dq_slot_node`

## Requirements
- R1: Each header output repeats its input one clock later. Fields change only on a cycle where the start-of-slot input is 1. On any other cycle all three fields pass through unchanged.
- R2: While the asynchronous active-low reset is asserted, all header outputs and the claim output are 0, and both counts and the queue are cleared. With no packet loaded, slots pass through unmodified.
- R3: Both counts saturate at `CNT_MAX` (default 15) and never go below zero. After 20 foreign requests, exactly 15 free slots are let through. A free slot seen with a zero count leaves the count at zero.
- R4: A queued request is written as request bit = 1 only on a reservation-bus slot whose incoming request bit is 0. The request is held until such a slot passes. Exactly one request is placed per queued packet, and request bits already set are never cleared.
- R5: A foreign request seen while the station has not yet placed its own raises the ahead count by one.
- R6: A foreign request seen after the station has placed its own raises the behind count by one.
- R7: A free data slot (busy = 0) seen while the ahead count is non-zero lowers that count by one and passes unmodified.
- R8: A free data slot seen while a packet is queued and the ahead count is zero leaves with busy = 1. The claim output is 1 in the same cycle that the slot appears at the output.
- R9: On a claim, the ahead count is loaded from the behind count, and the behind count is cleared.
- R10: The local queue is one deep. A load pulse while a packet is already queued is ignored, so only one claim follows.
- R11: A data slot with busy = 1 is never claimed and never changes a count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rsv_in_sos | input | 1 | Reservation bus: start-of-slot in |
| rsv_in_busy | input | 1 | Reservation bus: busy flag in |
| rsv_in_rsv | input | 1 | Reservation bus: request flag in |
| rsv_out_sos | output | 1 | Reservation bus: start-of-slot out |
| rsv_out_busy | output | 1 | Reservation bus: busy flag out |
| rsv_out_rsv | output | 1 | Reservation bus: request flag out |
| dat_in_sos | input | 1 | Data bus: start-of-slot in |
| dat_in_busy | input | 1 | Data bus: busy flag in |
| dat_in_rsv | input | 1 | Data bus: request flag in |
| dat_out_sos | output | 1 | Data bus: start-of-slot out |
| dat_out_busy | output | 1 | Data bus: busy flag out |
| dat_out_rsv | output | 1 | Data bus: request flag out |
| pkt_load | input | 1 | Pulse: put one packet in the local queue |
| tx_claim | output | 1 | Pulse: the outgoing data slot has been taken |

## Verification
Directed sequences first queue foreign requests, then the station's own request, then later foreign requests. Counting how many free slots pass before the claim tells ahead-counting apart from behind-counting and shows the hand-over on a claim. Separate patterns cover:
- busy slots and non-header cycles with a packet waiting, which separate a true free slot from lookalikes;
- back-to-back load pulses, for the queue depth;
- floods of requests and of free slots, which reach both saturation limits.

A long random mix of headers, loads and idle cycles is compared field by field against a bench model. This exposes ordering faults when several events land in the same cycle.

// File: rtl/dq_pkg.sv
package dq_pkg;
  typedef struct packed {
    logic sos;
    logic busy;
    logic rsv;
  } dq_hdr_t;
endpackage

// File: rtl/dq_req_queue.sv
module dq_req_queue (
  input  logic clk,
  input  logic rst_n,
  input  logic pkt_load_i,
  input  logic placed_i,
  input  logic sent_i,
  output logic q_full_o,
  output logic rq_pend_o
);
  logic full_q, full_d, pend_q, pend_d;

  always_comb begin
    full_d = full_q;
    pend_d = pend_q;
    if (sent_i) begin
      full_d = 1'b0;
      pend_d = 1'b0;
    end else if (placed_i) begin
      pend_d = 1'b0;
    end
    if (!full_q && pkt_load_i) begin
      full_d = 1'b1;
      pend_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      full_q <= full_d;
      pend_q <= pend_d;
    end
  end

  assign q_full_o  = full_q;
  assign rq_pend_o = pend_q;

  // R10: a queued packet stays until it is sent
  assert_load_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    full_q && !sent_i |=> full_q);
  // R4: once placed, no further request for the same packet
  assert_single_rsv_R4: assert property (@(posedge clk) disable iff (!rst_n)
    placed_i |=> !pend_q);
endmodule

// File: rtl/dq_rsv_tap.sv
module dq_rsv_tap
  import dq_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  dq_hdr_t hdr_i,
  input  logic    rq_pend_i,
  output dq_hdr_t hdr_o,
  output logic    placed_o,
  output logic    seen_o
);
  dq_hdr_t hdr_d, hdr_q;
  logic    up_q;

  always_comb begin
    placed_o = hdr_i.sos & rq_pend_i & ~hdr_i.rsv;
    seen_o   = hdr_i.sos & hdr_i.rsv;
    hdr_d    = hdr_i;
    if (placed_o) hdr_d.rsv = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hdr_q <= '0;
      up_q  <= 1'b0;
    end else begin
      hdr_q <= hdr_d;
      up_q  <= 1'b1;
    end
  end

  assign hdr_o = hdr_q;

  // R4: a request bit already set is never cleared
  assert_keep_rsv_R4: assert property (@(posedge clk) disable iff (!rst_n)
    up_q && $past(hdr_i.sos && hdr_i.rsv) |-> hdr_o.rsv);
  // R1: nothing changes off a slot start
  assert_mod_on_sos_R1: assert property (@(posedge clk) disable iff (!rst_n)
    up_q && !$past(hdr_i.sos) |-> hdr_o == $past(hdr_i));
endmodule

// File: rtl/dq_dat_tap.sv
module dq_dat_tap
  import dq_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  dq_hdr_t hdr_i,
  input  logic    q_full_i,
  input  logic    bef_zero_i,
  output dq_hdr_t hdr_o,
  output logic    tx_claim_o,
  output logic    sent_o,
  output logic    pass_o
);
  dq_hdr_t hdr_d, hdr_q;
  logic    claim_q, up_q, free_slot;

  always_comb begin
    free_slot = hdr_i.sos & ~hdr_i.busy;
    sent_o    = free_slot & q_full_i & bef_zero_i;
    pass_o    = free_slot & ~sent_o;
    hdr_d     = hdr_i;
    if (sent_o) hdr_d.busy = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hdr_q   <= '0;
      claim_q <= 1'b0;
      up_q    <= 1'b0;
    end else begin
      hdr_q   <= hdr_d;
      claim_q <= sent_o;
      up_q    <= 1'b1;
    end
  end

  assign hdr_o      = hdr_q;
  assign tx_claim_o = claim_q;

  // R8: a claim always rides on a slot start marked busy
  assert_claim_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_claim_o |-> hdr_o.sos && hdr_o.busy);
  // R11: a busy slot is never claimed
  assert_busy_untouched_R11: assert property (@(posedge clk) disable iff (!rst_n)
    up_q && $past(hdr_i.busy) |-> !tx_claim_o && hdr_o.busy);
  // R1: nothing changes off a slot start
  assert_dat_on_sos_R1: assert property (@(posedge clk) disable iff (!rst_n)
    up_q && !$past(hdr_i.sos) |-> hdr_o == $past(hdr_i) && !tx_claim_o);
endmodule

// File: rtl/dq_counters.sv
module dq_counters #(
  parameter int CNT_MAX = 15,
  localparam int CNT_W = $clog2(CNT_MAX + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic seen_i,
  input  logic own_placed_i,
  input  logic sent_i,
  input  logic pass_i,
  output logic bef_zero_o
);
  localparam logic [CNT_W:0] MAX_V = (CNT_W + 1)'(CNT_MAX);

  logic [CNT_W-1:0] bef_q, bef_d, aft_q, aft_d;
  logic [CNT_W:0]   bef_sum, aft_sum;
  logic             inc_bef, inc_aft, dec_bef;
  logic             up_q;

  always_comb begin
    inc_aft = seen_i & own_placed_i;
    inc_bef = seen_i & ~own_placed_i;
    dec_bef = pass_i & (bef_q != '0);
    if (sent_i) begin
      bef_sum = {1'b0, aft_q} + (CNT_W + 1)'(seen_i);
      aft_sum = '0;
    end else begin
      bef_sum = {1'b0, bef_q} - (CNT_W + 1)'(dec_bef) + (CNT_W + 1)'(inc_bef);
      aft_sum = {1'b0, aft_q} + (CNT_W + 1)'(inc_aft);
    end
    bef_d = (bef_sum > MAX_V) ? MAX_V[CNT_W-1:0] : bef_sum[CNT_W-1:0];
    aft_d = (aft_sum > MAX_V) ? MAX_V[CNT_W-1:0] : aft_sum[CNT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bef_q <= '0;
      aft_q <= '0;
      up_q  <= 1'b0;
    end else begin
      bef_q <= bef_d;
      aft_q <= aft_d;
      up_q  <= 1'b1;
    end
  end

  assign bef_zero_o = (bef_q == '0);

  // R3: no wrap at the top
  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    up_q && $past(bef_q) == MAX_V[CNT_W-1:0] && !$past(sent_i) |-> bef_q >= MAX_V[CNT_W-1:0] - 1'b1);
  // R3: no wrap at the bottom
  assert_no_underflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    up_q && $past(bef_q) == '0 && !$past(sent_i) |-> bef_q <= 1);
  // R9: the behind count is empty after a claim
  assert_aft_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sent_i |=> aft_q == '0);
  // R5: an ahead-counted request raises the count
  assert_bef_grow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    inc_bef && !pass_i && !sent_i && bef_q != MAX_V[CNT_W-1:0] |=> bef_q == $past(bef_q) + 1'b1);
endmodule

// File: rtl/dq_slot_node.sv
module dq_slot_node
  import dq_pkg::*;
#(
  parameter int CNT_MAX = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rsv_in_sos,
  input  logic rsv_in_busy,
  input  logic rsv_in_rsv,
  output logic rsv_out_sos,
  output logic rsv_out_busy,
  output logic rsv_out_rsv,
  input  logic dat_in_sos,
  input  logic dat_in_busy,
  input  logic dat_in_rsv,
  output logic dat_out_sos,
  output logic dat_out_busy,
  output logic dat_out_rsv,
  input  logic pkt_load,
  output logic tx_claim
);
  dq_hdr_t rsv_in, rsv_out, dat_in, dat_out;
  logic    q_full, rq_pend, placed, seen, sent, pass, bef_zero;

  assign rsv_in = '{sos: rsv_in_sos, busy: rsv_in_busy, rsv: rsv_in_rsv};
  assign dat_in = '{sos: dat_in_sos, busy: dat_in_busy, rsv: dat_in_rsv};

  dq_req_queue u_queue (
    .clk(clk), .rst_n(rst_n), .pkt_load_i(pkt_load), .placed_i(placed),
    .sent_i(sent), .q_full_o(q_full), .rq_pend_o(rq_pend)
  );

  dq_rsv_tap u_rsv (
    .clk(clk), .rst_n(rst_n), .hdr_i(rsv_in), .rq_pend_i(rq_pend),
    .hdr_o(rsv_out), .placed_o(placed), .seen_o(seen)
  );

  dq_dat_tap u_dat (
    .clk(clk), .rst_n(rst_n), .hdr_i(dat_in), .q_full_i(q_full),
    .bef_zero_i(bef_zero), .hdr_o(dat_out), .tx_claim_o(tx_claim),
    .sent_o(sent), .pass_o(pass)
  );

  dq_counters #(.CNT_MAX(CNT_MAX)) u_cnt (
    .clk(clk), .rst_n(rst_n), .seen_i(seen), .own_placed_i(q_full & ~rq_pend),
    .sent_i(sent), .pass_i(pass), .bef_zero_o(bef_zero)
  );

  assign rsv_out_sos  = rsv_out.sos;
  assign rsv_out_busy = rsv_out.busy;
  assign rsv_out_rsv  = rsv_out.rsv;
  assign dat_out_sos  = dat_out.sos;
  assign dat_out_busy = dat_out.busy;
  assign dat_out_rsv  = dat_out.rsv;
endmodule

// File: tb/sim_dq_slot_node.sv
`timescale 1ns/1ps
module sim_dq_slot_node;
  localparam int MAXC = 15;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rsv_in_sos = 0, rsv_in_busy = 0, rsv_in_rsv = 0;
  logic dat_in_sos = 0, dat_in_busy = 0, dat_in_rsv = 0;
  logic pkt_load = 0;
  logic rsv_out_sos, rsv_out_busy, rsv_out_rsv;
  logic dat_out_sos, dat_out_busy, dat_out_rsv;
  logic tx_claim;

  int checks = 0, errors = 0;
  int m_bef = 0, m_aft = 0;
  bit m_full = 0, m_pend = 0;
  logic [2:0] e_rsv = '0, e_dat = '0;
  logic e_claim = 0;
  logic obs_claim, obs_rsv, obs_busy;
  logic [2:0] obs_dat;

  always #2.5 clk = ~clk;

  dq_slot_node #(.CNT_MAX(MAXC)) u0 (
    .clk(clk), .rst_n(rst_n),
    .rsv_in_sos(rsv_in_sos), .rsv_in_busy(rsv_in_busy), .rsv_in_rsv(rsv_in_rsv),
    .rsv_out_sos(rsv_out_sos), .rsv_out_busy(rsv_out_busy), .rsv_out_rsv(rsv_out_rsv),
    .dat_in_sos(dat_in_sos), .dat_in_busy(dat_in_busy), .dat_in_rsv(dat_in_rsv),
    .dat_out_sos(dat_out_sos), .dat_out_busy(dat_out_busy), .dat_out_rsv(dat_out_rsv),
    .pkt_load(pkt_load), .tx_claim(tx_claim)
  );

  task automatic chk(input string tag, input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int sat(input int v);
    return (v > MAXC) ? MAXC : v;
  endfunction

  task automatic step(input bit rs, rb, rr, ds, db, dr, ld);
    bit seen, plc, own, snd, dec, was_full;
    @(negedge clk);
    chk("R4 reservation bus", {rsv_out_sos, rsv_out_busy, rsv_out_rsv}, e_rsv);
    chk("R8 data bus", {dat_out_sos, dat_out_busy, dat_out_rsv}, e_dat);
    chk("R8 claim", {2'b00, tx_claim}, {2'b00, e_claim});
    obs_claim = tx_claim; obs_rsv = rsv_out_rsv; obs_busy = dat_out_busy;
    obs_dat = {dat_out_sos, dat_out_busy, dat_out_rsv};
    rsv_in_sos = rs; rsv_in_busy = rb; rsv_in_rsv = rr;
    dat_in_sos = ds; dat_in_busy = db; dat_in_rsv = dr; pkt_load = ld;
    seen = rs && rr;
    plc = rs && !rr && m_pend;
    own = m_full && !m_pend;
    snd = ds && !db && m_full && (m_bef == 0);
    dec = ds && !db && !snd && (m_bef > 0);
    e_rsv = {rs, rb, rr | plc};
    e_dat = {ds, db | snd, dr};
    e_claim = snd;
    was_full = m_full;
    if (snd) begin
      m_bef = sat(m_aft + int'(seen));
      m_aft = 0; m_full = 0; m_pend = 0;
    end else begin
      m_bef = sat(m_bef - int'(dec) + int'(seen && !own));
      if (seen && own) m_aft = sat(m_aft + 1);
      if (plc) m_pend = 0;
    end
    if (!was_full && ld) begin m_full = 1; m_pend = 1; end
  endtask

  task automatic idle(); step(0,0,0,0,0,0,0); endtask
  task automatic rsv_slot(input bit rr); step(1,0,rr,0,0,0,0); idle(); endtask
  task automatic load(); step(0,0,0,0,0,0,1); endtask

  task automatic count_passes(output int n);
    n = 0;
    for (int i = 0; i < 40; i++) begin
      step(0,0,0,1,0,0,0);
      idle();
      if (obs_claim) break;
      n++;
    end
  endtask

  task automatic expect_int(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n;
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    // R2: reset state
    chk("R2 reset rsv", {rsv_out_sos, rsv_out_busy, rsv_out_rsv}, 3'b000);
    chk("R2 reset dat", {dat_out_sos, dat_out_busy, dat_out_rsv, tx_claim} >> 1, 3'b000);
    expect_int("R2 reset claim", int'(tx_claim), 0);
    rst_n = 1'b1;

    // R2: no packet, slots untouched
    step(1,0,0,1,0,0,0); idle();
    expect_int("R2 rsv untouched", int'(obs_rsv), 0);
    expect_int("R2 dat untouched", int'(obs_busy), 0);

    // R5/R6/R7/R4: three ahead, then own, then two behind
    rsv_slot(1); rsv_slot(1); rsv_slot(1);
    load();
    rsv_slot(1);                       // R5: still unplaced, counts ahead
    expect_int("R4 foreign bit kept", int'(obs_rsv), 1);
    rsv_slot(0);
    expect_int("R4 placed on clear slot", int'(obs_rsv), 1);
    rsv_slot(0);
    expect_int("R4 only once per packet", int'(obs_rsv), 0);
    rsv_slot(1); rsv_slot(1);          // R6: behind
    count_passes(n);
    expect_int("R5 R7 free slots let through", n, 4);
    // R9: behind count becomes ahead count
    load(); rsv_slot(0);
    count_passes(n);
    expect_int("R9 handover after claim", n, 2);

    // R11 and R1: busy slot and non-start cycle are never claimed
    load(); rsv_slot(0);
    step(0,0,0,1,1,0,0); idle();
    expect_int("R11 busy slot not claimed", int'(obs_claim), 0);
    step(0,0,0,0,0,1,0); idle();
    expect_int("R1 non-start cycle untouched", int'(obs_dat), 3'b001);
    count_passes(n);
    expect_int("R11 counts unchanged by busy slot", n, 0);

    // R10: second load while full ignored
    load(); load(); rsv_slot(0);
    count_passes(n);
    expect_int("R10 first packet sent", n, 0);
    for (int i = 0; i < 3; i++) begin
      step(0,0,0,1,0,0,0); idle();
      expect_int("R10 no second claim", int'(obs_claim), 0);
    end

    // R3: saturation at the top and at the bottom
    for (int i = 0; i < 20; i++) rsv_slot(1);
    load(); rsv_slot(0);
    count_passes(n);
    expect_int("R3 saturates at maximum", n, MAXC);
    for (int i = 0; i < 4; i++) step(0,0,0,1,0,0,0);
    load(); rsv_slot(0);
    count_passes(n);
    expect_int("R3 floor at zero", n, 0);

    // random mix against the model (R1 R4 R8)
    for (int i = 0; i < 4000; i++) begin
      step(($urandom % 3) == 0, $urandom % 2, ($urandom % 3) == 0,
           ($urandom % 3) == 0, ($urandom % 4) == 0, $urandom % 2,
           ($urandom % 6) == 0);
    end
    idle(); idle();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule